// File: doc/BRIEF.md
# Paged SPI Register Access Slave

This block lets a host processor reach a bank of 16-bit registers over a four-wire serial port. The registers are split into three pages: measurement results, general control and audio control. Every transaction opens with a 16-bit command word that names the direction, the page and a 6-bit register address. Data words follow while the select line stays low. After each word the address steps up by one, so a whole run of filter coefficients can be loaded in one burst, and a block of results can be read back the same way.

The serial pins are sampled by the fast system clock through a two-flop synchronizer. The engine works on edge events found in that clock domain. Each completed data word, and each read prefetch, also appears on a one-cycle parallel strobe with page, address and data, so the logic behind the registers can react to an access. The bank holds a parameterised number of registers per page. One data-page register, the 8-bit DAC setting, resets to midscale.

Top module: `spi_pg_regs`

## Requirements
- R1: `miso_oe` is 0 whenever `ss_n` is 1 and 1 whenever `ss_n` is 0. No bit is shifted in while `ss_n` is 1.
- R2: After reset every register reads 0000h, except page 0 address `DAC_ADDR` (default 2), which reads 0080h.
- R3: Command word layout: bit 15 = 1 means read and 0 means write; bits [12:11] are the page; bits [10:5] are the address. Command 10E0h is therefore a write to page 2, address 07h.
- R4: In a write, each further 16-bit data word lands at the next address. Each one gives exactly one `wr_stb` pulse, carrying the page, address and data of that word.
- R5: Read data goes out MSB first. `miso` changes only after a falling SCLK edge, so the host samples it on the rising edge. The first bit is valid for the rising edge that follows the command word.
- R6: A read gives `rd_stb` once when the command completes and once per completed data word. The address rises by one each time, so N words read back N consecutive registers.
- R7: If `ss_n` rises in the middle of a word, the partial word is dropped and nothing is written. The next transaction starts with a command word.
- R8: Writes to page 3, or to addresses at or above `REGS_PER_PAGE` (default 32), change nothing. Reads from those locations return 0000h.
- R9: `wr_stb` and `rd_stb` are never high in the same cycle. Each stays high for one system clock only. Neither fires in the cycle after `ss_n` (synchronized) was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 12 times the SCLK rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| ss_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host, idles low |
| mosi | input | 1 | Serial data from the host, sampled on SCLK rise |
| miso | output | 1 | Serial data to the host, updated after SCLK fall |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| wr_stb | output | 1 | One-cycle pulse per written data word |
| rd_stb | output | 1 | One-cycle pulse per read fetch |
| acc_page | output | 2 | Page of the current access |
| acc_addr | output | 6 | Address of the current access |
| acc_wdata | output | 16 | Data of the current write |

## Verification
The bench goes after the places where a serial slave slips by one: the first read bit must be ready at the falling edge right after the command, or the host would read a word shifted by one bit. A burst must step the address on every word; a design that stepped it only after the command, or not at all, would write every coefficient to one register. Select lines that drop mid-word, inside both the command and the data, check that no partial write lands and that the next frame decodes as a command instead of as data. Page 3 and out-of-range addresses check that there is no aliasing onto a real register.

// File: rtl/spi_pg_pkg.sv
package spi_pg_pkg;
  localparam int WORD_W = 16;
  localparam int PAGE_W = 2;
  localparam int ADDR_W = 6;

  typedef enum logic {PH_CMD, PH_DATA} phase_e;

  typedef struct packed {
    logic              rd;
    logic [PAGE_W-1:0] page;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

  // bit 15 direction, [12:11] page, [10:5] register
  function automatic cmd_t cmd_decode(input logic [WORD_W-1:0] w);
    cmd_t c;
    c.rd   = w[15];
    c.page = w[12:11];
    c.addr = w[10:5];
    return c;
  endfunction

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/spi_pg_sync.sv
module spi_pg_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/spi_pg_bank.sv
module spi_pg_bank import spi_pg_pkg::*; #(
  parameter int              PAGES   = 3,
  parameter int              REGS    = 32,
  parameter int              RST_ADR = 2,
  parameter logic [WORD_W-1:0] RST_VAL = 16'h0080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] page,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int RA_W = (REGS > 1) ? $clog2(REGS) : 1;

  logic [WORD_W-1:0] mem [PAGES][REGS];
  logic              hit;

  assign hit = ({1'b0, page} < (PAGE_W+1)'(PAGES)) &&
               ({1'b0, addr} < (ADDR_W+1)'(REGS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PAGES; p++)
        for (int r = 0; r < REGS; r++)
          mem[p][r] <= (p == 0 && r == RST_ADR) ? RST_VAL : '0;
    end else if (wr_en && hit) begin
      mem[page][addr[RA_W-1:0]] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) rdata = mem[page][addr[RA_W-1:0]];
  end
endmodule

// File: rtl/spi_pg_frame.sv
module spi_pg_frame import spi_pg_pkg::*; #(
  parameter int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_s,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic [WORD_W-1:0] rdata,
  output logic              wr_stb,
  output logic              rd_stb,
  output logic [PAGE_W-1:0] acc_page,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [WORD_W-1:0] acc_wdata,
  output logic              miso_q,
  output logic              rise_evt,
  output logic              fall_evt,
  output logic              ss_rise,
  output logic              word_done,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              in_cmd
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              sclk_d, ss_d, is_rd;
  phase_e            phase;
  logic [WORD_W-1:0] rx_sr, tx_sr, rx_next;
  logic [ADDR_W-1:0] cur_addr;
  cmd_t              cmd_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      ss_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      ss_d   <= ss_s;
    end
  end

  assign rise_evt  = ~ss_s & sclk_s & ~sclk_d;
  assign fall_evt  = ~ss_s & ~sclk_s & sclk_d;
  assign ss_rise   = ss_s & ~ss_d;
  assign word_done = rise_evt && (bit_cnt == LAST);
  assign rx_next   = {rx_sr[WORD_W-2:0], mosi_s};
  assign cmd_now   = cmd_decode(rx_next);
  assign in_cmd    = (phase == PH_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      miso_q    <= 1'b0;
      is_rd     <= 1'b0;
      cur_addr  <= '0;
      acc_page  <= '0;
      acc_addr  <= '0;
      acc_wdata <= '0;
      wr_stb    <= 1'b0;
      rd_stb    <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      if (ss_s) begin
        phase   <= PH_CMD;
        bit_cnt <= '0;
        tx_sr   <= '0;
        miso_q  <= 1'b0;
      end else begin
        if (rise_evt) begin
          rx_sr   <= rx_next;
          bit_cnt <= bit_cnt + 1'b1;
        end
        if (word_done) begin
          if (phase == PH_CMD) begin
            phase    <= PH_DATA;
            is_rd    <= cmd_now.rd;
            acc_page <= cmd_now.page;
            cur_addr <= cmd_now.addr;
            if (cmd_now.rd) begin
              rd_stb   <= 1'b1;
              acc_addr <= cmd_now.addr;
            end
          end else if (is_rd) begin
            rd_stb   <= 1'b1;
            acc_addr <= addr_step(cur_addr);
            cur_addr <= addr_step(cur_addr);
          end else begin
            wr_stb    <= 1'b1;
            acc_addr  <= cur_addr;
            acc_wdata <= rx_next;
            cur_addr  <= addr_step(cur_addr);
          end
        end
        if (fall_evt) begin
          miso_q <= tx_sr[WORD_W-1];
          tx_sr  <= {tx_sr[WORD_W-2:0], 1'b0};
        end
        if (rd_stb) tx_sr <= rdata;
      end
    end
  end
endmodule

// File: rtl/spi_pg_regs.sv
module spi_pg_regs import spi_pg_pkg::*; #(
  parameter int              REGS_PER_PAGE = 32,
  parameter int              NUM_PAGES     = 3,
  parameter int              DAC_ADDR      = 2,
  parameter logic [WORD_W-1:0] DAC_RESET   = 16'h0080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_n,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  output logic              wr_stb,
  output logic              rd_stb,
  output logic [PAGE_W-1:0] acc_page,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [WORD_W-1:0] acc_wdata
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [2:0]        pins_s;
  logic              ss_s, sclk_s, mosi_s;
  logic [WORD_W-1:0] rdata;
  logic              rise_evt, fall_evt, ss_rise, word_done, in_cmd;
  logic [CNT_W-1:0]  bit_cnt;

  spi_pg_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ss_n, sclk, mosi}), .q(pins_s)
  );
  assign {ss_s, sclk_s, mosi_s} = pins_s;

  spi_pg_frame #(.CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .ss_s(ss_s), .sclk_s(sclk_s), .mosi_s(mosi_s),
    .rdata(rdata), .wr_stb(wr_stb), .rd_stb(rd_stb), .acc_page(acc_page),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .miso_q(miso),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .ss_rise(ss_rise),
    .word_done(word_done), .bit_cnt(bit_cnt), .in_cmd(in_cmd)
  );

  spi_pg_bank #(
    .PAGES(NUM_PAGES), .REGS(REGS_PER_PAGE), .RST_ADR(DAC_ADDR), .RST_VAL(DAC_RESET)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_stb), .page(acc_page),
    .addr(acc_addr), .wdata(acc_wdata), .rdata(rdata)
  );

  assign miso_oe = ~ss_n;
endmodule

// File: rtl/spi_pg_regs_chk.sv
module spi_pg_regs_chk #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ss_s,
  input logic              miso,
  input logic              wr_stb,
  input logic              rd_stb,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              fall_evt,
  input logic              ss_rise,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              in_cmd
);
  logic              wr_seen, rd_seen;
  logic [ADDR_W-1:0] wr_last, rd_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_seen <= 1'b0; rd_seen <= 1'b0; wr_last <= '0; rd_last <= '0;
    end else if (ss_s) begin
      wr_seen <= 1'b0; rd_seen <= 1'b0;
    end else begin
      if (wr_stb) begin wr_seen <= 1'b1; wr_last <= acc_addr; end
      if (rd_stb) begin rd_seen <= 1'b1; rd_last <= acc_addr; end
    end
  end

  AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_seen) |-> (acc_addr == ADDR_W'(wr_last + 1'b1))); // R4
  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> ($past(fall_evt) || $past(ss_s))); // R5
  AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_seen) |-> (acc_addr == ADDR_W'(rd_last + 1'b1))); // R6
  AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ss_rise |=> (bit_cnt == '0 && in_cmd)); // R7
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_stb)); // R9
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R9
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb); // R9
  AST_NO_STB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ss_s) |-> !(wr_stb || rd_stb)); // R9
endmodule

bind spi_pg_regs spi_pg_regs_chk #(.ADDR_W(6), .CNT_W(4)) u_chk (
  .clk(clk), .rst_n(rst_n), .ss_s(ss_s), .miso(miso), .wr_stb(wr_stb),
  .rd_stb(rd_stb), .acc_addr(acc_addr), .fall_evt(fall_evt),
  .ss_rise(ss_rise), .bit_cnt(bit_cnt), .in_cmd(in_cmd)
);

// File: tb/spi_pg_regs_bench.sv
module spi_pg_regs_bench;
  localparam int HP = 8;
  localparam int NV = 6;
  // {page, addr, value}
  localparam logic [23:0] VEC [NV] = '{
    {2'd1, 6'd7,  16'h1234}, {2'd0, 6'd0,  16'hBEEF}, {2'd2, 6'd31, 16'h8001},
    {2'd2, 6'd0,  16'h00FF}, {2'd1, 6'd3,  16'hA5A5}, {2'd0, 6'd2,  16'h0042}
  };

  logic clk = 1'b0, rst_n = 1'b0, ss_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, miso_oe, wr_stb, rd_stb;
  logic [1:0]  acc_page;
  logic [5:0]  acc_addr;
  logic [15:0] acc_wdata;

  int total = 0, bad = 0, wr_cnt = 0, rd_cnt = 0, pulse_err = 0, r5_err = 0;
  logic [1:0]  last_wp;
  logic [5:0]  last_wa;
  logic [15:0] last_wd;
  logic        wr_prev = 1'b0, rd_prev = 1'b0;

  always #2 clk = ~clk;

  spi_pg_regs u_spi_pg_regs (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .acc_page(acc_page), .acc_addr(acc_addr), .acc_wdata(acc_wdata)
  );

  always @(posedge clk) begin
    if (wr_stb) begin
      wr_cnt++; last_wp = acc_page; last_wa = acc_addr; last_wd = acc_wdata;
    end
    if (rd_stb) rd_cnt++;
    if ((wr_stb && (wr_prev || rd_stb)) || (rd_stb && rd_prev)) pulse_err++;
    wr_prev = wr_stb;
    rd_prev = rd_stb;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] cmd(input logic rd, input logic [1:0] pg, input logic [5:0] ad);
    return {rd, 2'b00, pg, ad, 5'b00000};
  endfunction

  task automatic xbit(input logic b, output logic r);
    @(negedge clk) mosi = b;
    repeat (HP) @(negedge clk);
    sclk = 1'b1;
    r = miso;
    repeat (4) @(negedge clk);
    if (miso !== r) r5_err++;
    repeat (HP - 4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic xword(input logic [15:0] w, output logic [15:0] r);
    for (int i = 15; i >= 0; i--) xbit(w[i], r[i]);
  endtask

  task automatic sel_on();
    @(negedge clk) ss_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic sel_off();
    repeat (HP) @(negedge clk);
    ss_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wr1(input logic [1:0] pg, input logic [5:0] ad, input logic [15:0] d);
    logic [15:0] junk;
    sel_on();
    xword(cmd(1'b0, pg, ad), junk);
    xword(d, junk);
    sel_off();
  endtask

  task automatic rd1(input logic [1:0] pg, input logic [5:0] ad, output logic [15:0] d);
    logic [15:0] junk;
    sel_on();
    xword(cmd(1'b1, pg, ad), junk);
    xword(16'h0000, d);
    sel_off();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rv, junk;
    logic b;
    int c0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: output enable follows select
    chk("R1 oe idle", {31'd0, miso_oe}, 32'd0);
    @(negedge clk) ss_n = 1'b0;
    #1 chk("R1 oe selected", {31'd0, miso_oe}, 32'd1);
    @(negedge clk) ss_n = 1'b1;
    repeat (8) @(negedge clk);

    // R2: reset contents
    rd1(2'd0, 6'd2, rv);  chk("R2 dac reset", rv, 16'h0080);
    rd1(2'd0, 6'd0, rv);  chk("R2 page0 reset", rv, 16'h0000);
    rd1(2'd2, 6'd31, rv); chk("R2 page2 reset", rv, 16'h0000);

    // R4/R5: table walk, write then read back
    for (int i = 0; i < NV; i++) begin
      wr1(VEC[i][23:22], VEC[i][21:16], VEC[i][15:0]);
      chk("R4 strobe fields", {8'd0, last_wp, last_wa, last_wd}, {8'd0, VEC[i]});
      rd1(VEC[i][23:22], VEC[i][21:16], rv);
      chk("R5 readback", rv, VEC[i][15:0]);
    end

    // R3: literal command 10E0h -> write page 2 address 7
    sel_on();
    xword(16'h10E0, junk);
    xword(16'h5A5A, junk);
    sel_off();
    chk("R3 decode", {24'd0, last_wp, last_wa}, {24'd0, 2'd2, 6'd7});
    rd1(2'd2, 6'd7, rv); chk("R3 readback", rv, 16'h5A5A);

    // R4: burst write of four words from page 2 address 8
    c0 = wr_cnt;
    sel_on();
    xword(cmd(1'b0, 2'd2, 6'd8), junk);
    for (int k = 1; k <= 4; k++) xword(16'h1111 * k[15:0], junk);
    sel_off();
    chk("R4 burst strobes", wr_cnt - c0, 4);
    rd1(2'd2, 6'd10, rv); chk("R4 burst third", rv, 16'h3333);

    // R6: burst read of the same four words
    c0 = rd_cnt;
    sel_on();
    xword(cmd(1'b1, 2'd2, 6'd8), junk);
    for (int k = 1; k <= 4; k++) begin
      xword(16'h0000, rv);
      chk("R6 burst read", rv, 16'h1111 * k[15:0]);
    end
    sel_off();
    chk("R6 read strobes", rd_cnt - c0, 5);

    // R7: abort mid data word
    c0 = wr_cnt;
    sel_on();
    xword(cmd(1'b0, 2'd1, 6'd10), junk);
    for (int k = 0; k < 7; k++) xbit(1'b1, b);
    sel_off();
    chk("R7 no write", wr_cnt - c0, 0);
    rd1(2'd1, 6'd10, rv); chk("R7 untouched", rv, 16'h0000);
    // R7: abort mid command, next frame decodes as a command
    sel_on();
    for (int k = 0; k < 5; k++) xbit(1'b1, b);
    sel_off();
    c0 = wr_cnt;
    wr1(2'd1, 6'd11, 16'h7777);
    chk("R7 fresh command", wr_cnt - c0, 1);
    rd1(2'd1, 6'd11, rv); chk("R7 fresh readback", rv, 16'h7777);

    // R8: unmapped page and address
    wr1(2'd3, 6'd0, 16'hFFFF);
    rd1(2'd3, 6'd0, rv);  chk("R8 page3", rv, 16'h0000);
    wr1(2'd0, 6'd40, 16'hABCD);
    rd1(2'd0, 6'd40, rv); chk("R8 high addr", rv, 16'h0000);
    rd1(2'd0, 6'd8, rv);  chk("R8 no alias", rv, 16'h0000);

    chk("R5 miso stable at rise", r5_err, 0);
    chk("R9 strobe pulses", pulse_err, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule